// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (I2C-style, standard mode). It owns six 8-bit configuration registers whose values drive the parallel output `cfg_o` directly. A host loads the registers with a block write and reads them back with a block read. Both bus wires are sampled by a system clock that runs much faster than the bus. The block finds start, stop and bit edges on its own and pulls the data line low through an open-drain control output.

A write starts with the device address. Two further bytes follow, a command code and a byte count. The block acknowledges both and then throws them away. After that, data bytes fill the registers in a fixed order that always begins at register 0. A read returns a byte count first and then the register contents in ascending order. A set of strap inputs is captured once when reset is released. These values then appear, read-only, in the upper nibble of register 1.

Top module: `cfg_bus_slave`

## Requirements
- R1: The block acknowledges the 7-bit address 0x69: the byte 0xD2 for a write and 0xD3 for a read. It acknowledges by pulling SDA low for the ninth clock of the address byte. It does not acknowledge any other address, and it ignores the bus until the next start condition.
- R2: In a write, the first two bytes after the address are the command code and the byte count. Each is acknowledged and neither changes any register.
- R3: The data bytes of a write go to register 0, 1, 2 and so on up to register 5, in that order. Each byte is acknowledged. Register k appears on `cfg_o[8k+7:8k]`, and a register changes only when one of its own data bytes completes.
- R4: A stop may follow any complete byte. Registers already written keep their new values and the remaining registers keep their old ones. The next write starts again at register 0.
- R5: A data byte that arrives after register 5 has been written is acknowledged and discarded.
- R6: A read sends the byte count 0x06 first and then registers 0 to 5, most significant bit first. Each byte after the last register reads as 0xFF.
- R7: When the host does not acknowledge a byte of a read, the block stops sending and leaves SDA released until the next start condition.
- R8: After reset, register 0 holds 0x00 and registers 2 to 5 hold 0xFF. Register 1 holds ones in its writable low nibble.
- R9: Bits 7:4 of register 1 hold the strap inputs as they were sampled on the first clock after reset is released. Writes to these bits have no effect, and neither do later changes on the strap inputs.
- R10: The SDA pull-down switches on only while the synchronized SCL is low, and it is released after a stop.
- R11: A repeated start at any point begins a new address phase. Data bytes that completed before it keep their effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock wire level |
| sda_i | input | 1 | Serial data wire level |
| strap_i | input | STRAP_W | Strap levels, captured once after reset |
| sda_pull_o | output | 1 | 1 pulls the SDA wire low (open drain) |
| cfg_o | output | 8*NREG | Register contents, register k in bits 8k+7:8k |

## Verification
The bench builds the block with six registers, a four-bit strap field and a three-stage input synchronizer. The longer synchronizer delays every edge the block sees by an extra cycle. This checks that acknowledge and data bits still settle well inside the SCL low phase. With the default register count, the bench can drive writes that run past the last register and reads that run past the register bank. It can also cover the saturating byte index and the 0xFF filler bytes.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_RX,
    LK_RACK,
    LK_TX,
    LK_TACK
  } link_st_e;
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~last;
  assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/cfgs_link.sv
module cfgs_link
  import cfgs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         IDXW     = 4,
  parameter int         IDX_MAX  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_rise,
  input  logic            sda_fall,
  input  logic [7:0]      rd_data,
  output logic [IDXW-1:0] rd_idx,
  output logic            wr_stb,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic            sda_pull,
  output logic            start_det,
  output logic            stop_det
);
  link_st_e        st;
  logic [3:0]      cnt;
  logic [7:0]      sh;
  logic            rw;
  logic            nack;
  logic [IDXW-1:0] byte_idx;
  logic [IDXW-1:0] nxt_idx;

  assign start_det = scl_s & sda_fall;
  assign stop_det  = scl_s & sda_rise;
  assign nxt_idx   = (byte_idx == IDXW'(IDX_MAX)) ? byte_idx : byte_idx + 1'b1;
  assign rd_idx    = (st == LK_AACK) ? '0 : nxt_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= LK_IDLE;
      cnt      <= '0;
      sh       <= '0;
      rw       <= 1'b0;
      nack     <= 1'b0;
      byte_idx <= '0;
      sda_pull <= 1'b0;
      wr_stb   <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        st       <= LK_ADDR;
        cnt      <= '0;
        byte_idx <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= LK_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          LK_IDLE: ;
          LK_ADDR, LK_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == LK_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw       <= sh[0];
                  sda_pull <= 1'b1;
                  st       <= LK_AACK;
                end else begin
                  st <= LK_IDLE;
                end
              end else begin
                sda_pull <= 1'b1;
                wr_stb   <= 1'b1;
                wr_idx   <= byte_idx;
                wr_data  <= sh;
                st       <= LK_RACK;
              end
            end
          end
          LK_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh       <= rd_data;
                sda_pull <= ~rd_data[7];
                st       <= LK_TX;
              end else begin
                sda_pull <= 1'b0;
                st       <= LK_RX;
              end
            end
          end
          LK_RACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              byte_idx <= nxt_idx;
              st       <= LK_RX;
            end
          end
          LK_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_pull <= 1'b0;
                cnt      <= '0;
                st       <= LK_TACK;
              end else begin
                sh       <= {sh[6:0], 1'b0};
                sda_pull <= ~sh[6];
                cnt      <= cnt + 1'b1;
              end
            end
          end
          LK_TACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                st <= LK_IDLE;
              end else begin
                byte_idx <= nxt_idx;
                sh       <= rd_data;
                sda_pull <= ~rd_data[7];
                cnt      <= '0;
                st       <= LK_TX;
              end
            end
          end
          default: st <= LK_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgs_regs.sv
module cfgs_regs #(
  parameter int NREG    = 6,
  parameter int STRAP_W = 4,
  parameter int IDXW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IDXW-1:0]   rd_idx,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [7:0]        rd_data,
  output logic [8*NREG-1:0] cfg_o
);
  localparam int STRAP_REG = 1;
  localparam int LOW_W     = 8 - STRAP_W;

  logic [STRAP_W-1:0] strap_q;
  logic               strap_done;
  logic [7:0]         view [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= '0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= strap_i;
      strap_done <= 1'b1;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    if (k == STRAP_REG) begin : g_strap
      logic [LOW_W-1:0] low;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          low <= '1;
        else if (wr_stb && wr_idx == IDXW'(k + 2))
          low <= wr_data[LOW_W-1:0];
      end
      assign view[k] = {strap_q, low};
    end else begin : g_full
      localparam logic [7:0] RST_VAL = (k == 0) ? 8'h00 : 8'hFF;
      logic [7:0] full;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          full <= RST_VAL;
        else if (wr_stb && wr_idx == IDXW'(k + 2))
          full <= wr_data;
      end
      assign view[k] = full;
    end
    assign cfg_o[8*k +: 8] = view[k];
  end

  always_comb begin
    rd_data = 8'hFF;
    if (rd_idx == '0) rd_data = 8'(NREG);
    for (int k = 0; k < NREG; k++) begin
      if (rd_idx == IDXW'(k + 1)) rd_data = view[k];
    end
  end
endmodule

// File: rtl/cfg_bus_slave.sv
module cfg_bus_slave #(
  parameter int         NREG        = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter int         STRAP_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_pull_o,
  output logic [8*NREG-1:0]  cfg_o
);
  localparam int IDX_MAX = NREG + 2;
  localparam int IDXW    = $clog2(IDX_MAX + 1);

  logic            scl_s, scl_rise, scl_fall;
  logic            sda_s, sda_rise, sda_fall;
  logic [IDXW-1:0] rd_idx, wr_idx;
  logic [7:0]      rd_data, wr_data;
  logic            wr_stb, start_det, stop_det;

  cfgs_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .din(scl_i),
    .dout(scl_s), .rise(scl_rise), .fall(scl_fall)
  );

  cfgs_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .din(sda_i),
    .dout(sda_s), .rise(sda_rise), .fall(sda_fall)
  );

  cfgs_link #(.DEV_ADDR(DEV_ADDR), .IDXW(IDXW), .IDX_MAX(IDX_MAX)) u_link (
    .clk(clk), .rst_n(rst_n),
    .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_rise(sda_rise), .sda_fall(sda_fall),
    .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_pull(sda_pull_o), .start_det(start_det), .stop_det(stop_det)
  );

  cfgs_regs #(.NREG(NREG), .STRAP_W(STRAP_W), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .strap_i(strap_i),
    .rd_data(rd_data), .cfg_o(cfg_o)
  );
endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk #(
  parameter int NREG    = 6,
  parameter int STRAP_W = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             scl_s,
  input logic                             sda_pull_o,
  input logic                             stop_det,
  input logic                             wr_stb,
  input logic [$clog2(NREG+3)-1:0]        wr_idx,
  input logic [8*NREG-1:0]                cfg_o
);
  logic [1:0] armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= '0;
    else if (armed != 2'd2) armed <= armed + 1'b1;
  end

  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(!scl_s));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);

  // R3
  cfg_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed == 2'd2 && $changed(cfg_o)) |-> $past(wr_stb));

  // R2
  ctrl_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx < 2) |=> $stable(cfg_o));

  // R5
  overflow_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(wr_idx) > NREG + 1) |=> $stable(cfg_o));

  // R9
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed == 2'd2) |-> $stable(cfg_o[15 -: STRAP_W]));
endmodule

bind cfg_bus_slave cfgs_chk #(.NREG(NREG), .STRAP_W(STRAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .stop_det(stop_det), .wr_stb(wr_stb), .wr_idx(wr_idx), .cfg_o(cfg_o)
);

// File: tb/tb_cfg_bus_slave.sv
module tb_cfg_bus_slave;
  localparam int NREG = 6;
  localparam int Q    = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_h = 1'b1;
  logic        sda_h = 1'b1;
  logic        sda_line;
  logic [3:0]  strap = 4'hA;
  logic        sda_pull;
  logic [47:0] cfg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_reg [NREG];
  logic [3:0] strap_m;
  logic [7:0] wbuf [10];
  logic [7:0] rbuf [10];

  always #2 clk = ~clk;
  assign sda_line = sda_h & ~sda_pull;

  cfg_bus_slave #(.SYNC_STAGES(3)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .strap_i(strap), .sda_pull_o(sda_pull), .cfg_o(cfg)
  );

  function automatic logic [7:0] view(input int k);
    if (k == 1) return {strap_m, exp_reg[1][3:0]};
    return exp_reg[k];
  endfunction

  function automatic logic [47:0] exp_cfg();
    logic [47:0] v;
    for (int k = 0; k < NREG; k++) v[8*k +: 8] = view(k);
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    if (i == 0) return 8'h06;
    if (i <= NREG) return view(i - 1);
    return 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wait_q();
    scl_h = 1'b1; wait_q();
    sda_h = 1'b0; wait_q();
    scl_h = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wait_q();
    scl_h = 1'b1; wait_q();
    sda_h = 1'b1; wait_q(); wait_q();
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; wait_q();
    scl_h = 1'b1; wait_q(); wait_q();
    scl_h = 1'b0; wait_q();
  endtask

  task automatic recv_bit(output logic b);
    sda_h = 1'b1; wait_q();
    scl_h = 1'b1; wait_q();
    b = sda_line; wait_q();
    scl_h = 1'b0; wait_q();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  // write transaction: address, command, count, n data bytes from wbuf
  task automatic wr_txn(input logic [7:0] addr, input int n, input string req);
    logic a, all;
    bus_start();
    write_byte(addr, a);
    chk({req, " R1 addr ack"}, a, addr == 8'hD2);
    all = 1'b1;
    write_byte(8'($urandom), a); all &= a;
    write_byte(8'($urandom), a); all &= a;
    for (int i = 0; i < n; i++) begin
      write_byte(wbuf[i], a);
      all &= a;
    end
    bus_stop();
    if (addr == 8'hD2) begin
      chk({req, " R2 R3 byte acks"}, all, 1'b1);
      for (int i = 0; i < n && i < NREG; i++) exp_reg[i] = wbuf[i];
    end else begin
      chk({req, " R1 no ack foreign"}, all, 1'b0);
    end
    chk({req, " R10 released after stop"}, sda_pull, 1'b0);
    chk({req, " cfg_o"}, cfg, exp_cfg());
  endtask

  task automatic rd_txn(input int n, input string req);
    logic a;
    bus_start();
    write_byte(8'hD3, a);
    chk({req, " R1 read addr ack"}, a, 1'b1);
    for (int i = 0; i < n; i++) read_byte(rbuf[i], i == n - 1);
    bus_stop();
    for (int i = 0; i < n; i++) chk({req, " R6 read byte"}, rbuf[i], exp_rd(i));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    void'($urandom(32'h00C0FFEE));
    exp_reg[0] = 8'h00;
    for (int k = 1; k < NREG; k++) exp_reg[k] = 8'hFF;
    strap_m = 4'hA;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    strap = 4'h5;  // later strap change must be ignored (R9)
    repeat (5) @(negedge clk);
    chk("R8 reset values", cfg, 48'hFFFF_FFFF_AF00);
    chk("R8 SDA idle", sda_pull, 1'b0);

    // R3 full write; R9 register 1 upper nibble write ignored
    wbuf[0] = 8'h3C; wbuf[1] = 8'h00; wbuf[2] = 8'h81;
    wbuf[3] = 8'h7E; wbuf[4] = 8'h55; wbuf[5] = 8'hC3;
    wr_txn(8'hD2, 6, "R3 R9 full write");
    chk("R9 strap nibble", cfg[15:12], 4'hA);
    rd_txn(7, "R6 full read");

    // R2 only command and count
    wr_txn(8'hD2, 0, "R2 control only");
    // R4 partial write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_txn(8'hD2, 2, "R4 partial");
    // R5 overrun
    for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'hA0 + i);
    wr_txn(8'hD2, 9, "R5 overrun");
    // R1 foreign address
    wbuf[0] = 8'h99; wbuf[1] = 8'h98; wbuf[2] = 8'h97;
    wr_txn(8'hA4, 3, "R1 foreign");
    // R6 read past bank
    rd_txn(9, "R6 past bank");

    // R7 early NACK then SDA stays released
    bus_start();
    write_byte(8'hD3, a);
    read_byte(d, 1'b0);
    chk("R7 count byte", d, 8'h06);
    read_byte(d, 1'b1);
    chk("R7 reg0 byte", d, view(0));
    read_byte(d, 1'b1);
    chk("R7 released after nack", d, 8'hFF);
    bus_stop();

    // R11 repeated start after one data byte
    bus_start();
    write_byte(8'hD2, a);
    write_byte(8'h00, a);
    write_byte(8'h06, a);
    write_byte(8'h5A, a);
    exp_reg[0] = 8'h5A;
    bus_start();
    write_byte(8'hD3, a);
    chk("R11 readdress ack", a, 1'b1);
    read_byte(d, 1'b0);
    chk("R11 count", d, 8'h06);
    read_byte(d, 1'b1);
    chk("R11 reg0 kept", d, 8'h5A);
    bus_stop();
    chk("R11 cfg", cfg, exp_cfg());

    // random block writes, each followed by a full read (R3 R4 R5 R6)
    for (int it = 0; it < 5; it++) begin
      int n;
      n = $urandom_range(0, 8);
      for (int i = 0; i < 10; i++) wbuf[i] = 8'($urandom);
      wr_txn(8'hD2, n, "R4 random write");
      rd_txn(7, "R6 random read");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule